// File: doc/BRIEF.md
# Range Cache-Maintenance Step Unit

This block carries out one step of an address-range cache maintenance operation on a design that works on one cache line per execution. A command gives a start address, the number of bytes software still wants covered, a two-bit operation code, a hint flag and a fault flag. The unit works out how many bytes of the range fall inside the line that holds the start address. It sends one line command for that line to the cache over a valid/ready port, and then returns the number of bytes it covered.

Software runs the step in a loop. After each step it adds the returned count to the start address and subtracts it from the remaining length, and it stops when nothing is left. A returned count of zero means no cache operation took place. This happens when the requested length is zero, when the fault flag is set (so the loop can be restarted once the fault has been handled), or when the command is a hint with no destination register and is dropped. The count is computed using only adders and comparators as wide as the line offset. No comparison spans the full address width.

Top module: `rcs_step_unit`

## Requirements
- R1: After reset, `line_valid` and `res_valid` are 0 and `cmd_ready` is 1.
- R2: When the start address is line-aligned and the requested length is at least one line, the reported length equals the line size (64 bytes by default).
- R3: When the start address is not aligned, the reported length is the smaller of the requested length and the line size minus (start address modulo line size).
- R4: A requested length of zero reports 0 and issues no line command.
- R5: When `cmd_fault` is 1 at acceptance, no line command is issued and the reported length is 0.
- R6: When `cmd_hint` is 1 at acceptance, the command is dropped: no line command is issued and the reported length is 0.
- R7: A line command carries the start address with its low log2(line size) bits cleared. It also carries the command's operation code unchanged: 0 clean, 1 invalidate, 2 flush, 3 zero.
- R8: `line_valid` stays high with `line_addr` and `line_op` unchanged until `line_ready` is seen. `res_valid` rises in the cycle after that handshake.
- R9: Each accepted command yields at most one line command and exactly one single-cycle `res_valid` pulse. `cmd_ready` is low from acceptance until the pulse has ended.
- R10: Repeating the step while advancing the start address and reducing the remaining length by the reported count covers an arbitrary range exactly, with one step per line touched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Step command present |
| cmd_ready | output | 1 | Unit idle and accepting a command |
| cmd_base | input | ADDR_W | Start address of the remaining range |
| cmd_len | input | LEN_W | Remaining requested length in bytes |
| cmd_op | input | 2 | Operation: 0 clean, 1 invalidate, 2 flush, 3 zero |
| cmd_hint | input | 1 | Destination is the zero register; the step may be dropped |
| cmd_fault | input | 1 | Translation fault seen for this step; suppress the operation |
| line_valid | output | 1 | Line command valid |
| line_ready | input | 1 | Cache accepts the line command |
| line_addr | output | ADDR_W | Line-aligned address of the targeted line |
| line_op | output | 2 | Operation code for the line |
| res_valid | output | 1 | Single-cycle pulse: reported length valid |
| res_len | output | OFS_W+1 | Bytes covered by this step |

## Verification
The assertions assume two things. First, `cmd_base`, `cmd_len`, `cmd_op`, `cmd_hint` and `cmd_fault` are only meaningful in the acceptance cycle. Second, `line_ready` may stall for any number of cycles but is eventually given. The bench drives each command for exactly one cycle while `cmd_ready` is high and then lowers `cmd_valid`. It raises `line_ready` only while a line command is pending, after a chosen number of wait states, and drops it again once the handshake is done. No second command is presented until the result pulse has ended.

// File: rtl/rcs_pkg.sv
// Shared types for the range cache-op step unit.
// Assumes: the operation encoding is fixed and is decoded by the cache port.
package rcs_pkg;
    typedef enum logic [1:0] {
        OP_CLEAN = 2'd0,
        OP_INVAL = 2'd1,
        OP_FLUSH = 2'd2,
        OP_ZERO  = 2'd3
    } line_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DONE = 2'd2
    } step_state_e;
endpackage

// File: rtl/rcs_len_calc.sv
// Achieved-length calculation for one step.
// Computes min(requested, bytes left in the line) using only
// offset-width arithmetic; higher length bits are merely OR-reduced.
// Assumes: LINE_BYTES is a power of two.
module rcs_len_calc #(
    parameter int LEN_W      = 32,
    parameter int LINE_BYTES = 64,
    localparam int OFS_W     = $clog2(LINE_BYTES)
) (
    input  logic [OFS_W-1:0] base_ofs,
    input  logic [LEN_W-1:0] req_len,
    output logic [OFS_W:0]   ach_len
);
    localparam logic [OFS_W:0] LINE_V = (OFS_W+1)'(LINE_BYTES);

    logic [OFS_W:0] room;
    logic [OFS_W:0] len_lo;
    logic           len_hi_set;

    // Bytes from the start address to the end of its line.
    always_comb room = LINE_V - {1'b0, base_ofs};

    // Split the requested length into an offset-width part and an overflow flag.
    generate
        if (LEN_W > OFS_W + 1) begin : g_wide_len
            always_comb begin
                len_lo     = req_len[OFS_W:0];
                len_hi_set = |req_len[LEN_W-1:OFS_W+1];
            end
        end else begin : g_narrow_len
            always_comb begin
                len_lo     = (OFS_W+1)'(req_len);
                len_hi_set = 1'b0;
            end
        end
    endgenerate

    // Clip the request to the room left in the line.
    always_comb ach_len = (len_hi_set || (len_lo >= room)) ? room : len_lo;
endmodule

// File: rtl/rcs_line_port.sv
// Line-command output register with valid/ready handshake.
// Holds address and operation stable until the cache accepts them.
// Assumes: load is only pulsed while no command is pending.
module rcs_line_port #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [ADDR_W-OFS_W-1:0] load_line,
    input  logic [1:0]              load_op,
    input  logic                    line_ready,
    output logic                    line_valid,
    output logic [ADDR_W-1:0]       line_addr,
    output logic [1:0]              line_op,
    output logic                    fire
);
    logic [ADDR_W-OFS_W-1:0] line_q;

    // Handshake completes when valid meets ready.
    always_comb fire = line_valid && line_ready;

    // Pending flag: set on load, cleared on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)    line_valid <= 1'b0;
        else if (load) line_valid <= 1'b1;
        else if (fire) line_valid <= 1'b0;
    end

    // Capture the line number and operation on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q  <= '0;
            line_op <= 2'd0;
        end else if (load) begin
            line_q  <= load_line;
            line_op <= load_op;
        end
    end

    // Present the line number as an aligned byte address.
    always_comb line_addr = {line_q, {OFS_W{1'b0}}};

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !line_ready) |=> (line_valid && $stable(line_addr) && $stable(line_op)));

    a_r8_drop_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !line_valid);
endmodule

// File: rtl/rcs_step_ctrl.sv
// Step sequencer: accept a command, optionally wait for the line
// handshake, then pulse the result for one cycle.
// Assumes: skip is valid in the acceptance cycle.
module rcs_step_ctrl
    import rcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic skip,
    input  logic fire,
    output logic cmd_ready,
    output logic accept,
    output logic load_req,
    output logic res_valid
);
    step_state_e state;

    // Idle accepts; acceptance with work starts a line command.
    always_comb begin
        cmd_ready = (state == ST_IDLE);
        accept    = cmd_ready && cmd_valid;
        load_req  = accept && !skip;
        res_valid = (state == ST_DONE);
    end

    // State register: IDLE -> REQ -> DONE -> IDLE, or IDLE -> DONE when skipped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (accept) state <= skip ? ST_DONE : ST_REQ;
                ST_REQ:  if (fire)   state <= ST_DONE;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r8_result_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> res_valid);
endmodule

// File: rtl/rcs_step_unit.sv
// Range cache-op step unit (top).
// Covers the part of a byte range that lies in the line of the start
// address, issues one line command for it, and reports the bytes covered.
// Assumes: command fields are sampled only in the acceptance cycle.
module rcs_step_unit #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 32,
    parameter int LINE_BYTES = 64,
    localparam int OFS_W     = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_hint,
    input  logic              cmd_fault,
    output logic              line_valid,
    input  logic              line_ready,
    output logic [ADDR_W-1:0] line_addr,
    output logic [1:0]        line_op,
    output logic              res_valid,
    output logic [OFS_W:0]    res_len
);
    logic [OFS_W:0] calc_len;
    logic [OFS_W:0] step_len;
    logic           skip;
    logic           accept;
    logic           load_req;
    logic           fire;

    rcs_len_calc #(
        .LEN_W      (LEN_W),
        .LINE_BYTES (LINE_BYTES)
    ) i_len_calc (
        .base_ofs (cmd_base[OFS_W-1:0]),
        .req_len  (cmd_len),
        .ach_len  (calc_len)
    );

    // Faulted or hinted steps make no progress; a zero length does so already.
    always_comb begin
        step_len = (cmd_fault || cmd_hint) ? '0 : calc_len;
        skip     = (step_len == '0);
    end

    rcs_step_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .skip      (skip),
        .fire      (fire),
        .cmd_ready (cmd_ready),
        .accept    (accept),
        .load_req  (load_req),
        .res_valid (res_valid)
    );

    rcs_line_port #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W)
    ) i_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_req),
        .load_line  (cmd_base[ADDR_W-1:OFS_W]),
        .load_op    (cmd_op),
        .line_ready (line_ready),
        .line_valid (line_valid),
        .line_addr  (line_addr),
        .line_op    (line_op),
        .fire       (fire)
    );

    // Latch the achieved length at acceptance for the result pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)      res_len <= '0;
        else if (accept) res_len <= step_len;
    end

    a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_len <= (OFS_W+1)'(LINE_BYTES)));

    a_r5_fault_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_fault) |=> (!line_valid && res_valid && res_len == '0));

    a_r6_hint_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_hint) |=> !line_valid);

    a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> !cmd_ready);

    a_r7_progress_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (res_len != '0));
endmodule

// File: tb/test_rcs_step_unit.sv
module test_rcs_step_unit;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 32;
    localparam int LINE   = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [ADDR_W-1:0] cmd_base = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic [1:0]        cmd_op = 2'd0;
    logic              cmd_hint = 1'b0;
    logic              cmd_fault = 1'b0;
    logic              line_valid;
    logic              line_ready = 1'b0;
    logic [ADDR_W-1:0] line_addr;
    logic [1:0]        line_op;
    logic              res_valid;
    logic [6:0]        res_len;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Outcome of the last step.
    int          got_len;
    int          got_reqs;
    logic [31:0] got_addr;
    logic [1:0]  got_op;

    always #10 clk = ~clk;

    rcs_step_unit #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE)) i_rcs_step_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_base(cmd_base), .cmd_len(cmd_len), .cmd_op(cmd_op), .cmd_hint(cmd_hint),
        .cmd_fault(cmd_fault), .line_valid(line_valid), .line_ready(line_ready),
        .line_addr(line_addr), .line_op(line_op), .res_valid(res_valid), .res_len(res_len)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one command and follow it to its result pulse.
    task automatic step(input logic [31:0] base, input logic [31:0] len, input logic [1:0] op,
                        input logic hint, input logic fault, input int delay);
        int  wait_cnt = 0;
        bit  got = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_base = base; cmd_len = len; cmd_op = op;
        cmd_hint = hint; cmd_fault = fault;
        got_reqs = 0; got_len = -1; got_addr = '0; got_op = 2'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 40 && !got; i++) begin
            if (line_valid) begin
                if (got_reqs == 0) begin
                    got_reqs = 1; got_addr = line_addr; got_op = line_op;
                    chk("R9 cmd_ready low while busy", cmd_ready, 0);
                end else begin
                    chk("R8 address held", line_addr, got_addr);
                end
                line_ready = (wait_cnt >= delay);
                wait_cnt++;
            end else begin
                line_ready = 1'b0;
            end
            if (res_valid) begin
                got_len = res_len;
                got = 1;
            end else begin
                @(negedge clk);
            end
        end
        line_ready = 1'b0;
        @(negedge clk);
        chk("R9 result pulse ends", res_valid, 0);
        chk("R9 ready after pulse", cmd_ready, 1);
    endtask

    // Run one step and compare against the model built from the requirements.
    task automatic run_case(input string tag, input logic [31:0] base, input logic [31:0] len,
                            input logic [1:0] op, input logic hint, input logic fault, input int delay);
        longint room = LINE - (base % LINE);
        longint exp  = (fault || hint || len == 0) ? 0 : ((len < room) ? len : room);
        step(base, len, op, hint, fault, delay);
        chk({tag, " length"}, got_len, exp);
        chk({tag, " request count"}, got_reqs, (exp != 0) ? 1 : 0);
        if (exp != 0) begin
            chk({tag, " R7 line address"}, got_addr, base & ~32'(LINE - 1));
            chk({tag, " R7 op code"}, got_op, op);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 line_valid at reset", line_valid, 0);
        chk("R1 res_valid at reset", res_valid, 0);
        chk("R1 cmd_ready at reset", cmd_ready, 1);
    endtask

    task automatic t_aligned;
        run_case("R2 aligned long", 32'h0000_1000, 32'd500, 2'd0, 0, 0, 0);
        run_case("R2 aligned exact line", 32'h0000_2040, 32'd64, 2'd1, 0, 0, 0);
        run_case("R2 aligned huge length", 32'hFFFF_FFC0, 32'hFFFF_FFFF, 2'd2, 0, 0, 0);
    endtask

    task automatic t_unaligned;
        run_case("R3 unaligned clipped", 32'h0000_1010, 32'd200, 2'd3, 0, 0, 0);
        run_case("R3 unaligned inside line", 32'h0000_1010, 32'd5, 2'd0, 0, 0, 0);
        run_case("R3 last byte of line", 32'h0000_303F, 32'd100, 2'd1, 0, 0, 0);
        run_case("R3 ends exactly at line end", 32'h0000_3020, 32'd32, 2'd2, 0, 0, 0);
        run_case("R2 aligned short", 32'h0000_4000, 32'd63, 2'd3, 0, 0, 0);
    endtask

    task automatic t_zero_len;
        run_case("R4 zero length", 32'h0000_1234, 32'd0, 2'd0, 0, 0, 0);
    endtask

    task automatic t_fault;
        run_case("R5 fault", 32'h0000_5000, 32'd256, 2'd2, 0, 1, 0);
    endtask

    task automatic t_hint;
        run_case("R6 hint dropped", 32'h0000_6000, 32'd256, 2'd1, 1, 0, 0);
    endtask

    task automatic t_stall;
        run_case("R8 stalled ready", 32'h0000_7008, 32'd1000, 2'd3, 0, 0, 4);
        run_case("R8 long stall", 32'h0000_7100, 32'd64, 2'd1, 0, 0, 9);
    endtask

    task automatic t_range_walk;
        logic [31:0] base = 32'h0000_8010;
        logic [31:0] left = 32'd200;
        int steps = 0;
        int total = 0;
        while (left != 0 && steps < 20) begin
            step(base, left, 2'd2, 0, 0, steps % 3);
            if (got_len <= 0) break;
            chk("R10 one request per step", got_reqs, 1);
            base  = base + got_len;
            left  = left - got_len;
            total = total + got_len;
            steps++;
        end
        chk("R10 bytes covered", total, 200);
        chk("R10 step count", steps, 4);
        chk("R10 final address", base, 32'h0000_80D8);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_aligned();
        t_unaligned();
        t_zero_len();
        t_fault();
        t_hint();
        t_stall();
        t_range_walk();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule